// File: doc/BRIEF.md
# Seven-Slot Pixel Serializer with Selectable Lane Mapping

This block turns one parallel pixel (8-bit red, green and blue, plus horizontal sync, vertical sync and data-enable) into seven serial time slots on each of four data lanes, plus a clock lane, for a 7:1 flat-panel link. It runs on a single serial clock at seven times the pixel rate. An internal slot counter marks the pixel boundary with `pix_load`. The pixel source presents the next pixel while `pix_load` is high, and the block captures it on that clock edge.

A static selector picks one of three colour-to-slot orderings, or a reserved code that silences the data lanes. The orderings are an 18-bit layout on three lanes, a 24-bit layout with the two low bits of each colour on lane 3, and a 24-bit layout with the two high bits on lane 3. A mirror input reverses the slot order on all data lanes. The selector and mirror are sampled together with the pixel, so a change takes effect at the next pixel boundary. The differential drivers, the PLL and lane deskew sit outside this block.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: While reset is held, and until the first capture, every data lane and the clock lane are low and `pix_load` is high.
- R2: `pix_load` is high in exactly one cycle out of every seven. The pixel inputs, `map_sel` and `mirror` are captured on the clock edge where it is high. The next cycle is wire slot 0 of that pixel, and wire slots 1 to 6 follow in the next six cycles.
- R3: The clock lane sends 1,1,0,0,0,1,1 in wire slots 0 to 6, whatever `map_sel` and `mirror` are.
- R4: With `map_sel`=0 (18-bit), red[7:2], green[7:2] and blue[7:2] are used as 6-bit colours R5..R0, G5..G0 and B5..B0. In slots 0 to 6, lane 0 sends G0,R5,R4,R3,R2,R1,R0. Lane 1 sends B1,B0,G5,G4,G3,G2,G1. Lane 2 sends DE,VS,HS,B5,B4,B3,B2. Lane 3 is held low.
- R5: With `map_sel`=1, lanes 0 to 2 match R4, using bits 7..2 of each channel. Lane 3 sends 0,b[1],b[0],g[1],g[0],r[1],r[0] in slots 0 to 6.
- R6: With `map_sel`=2, lane 0 sends g[0],r[5],r[4],r[3],r[2],r[1],r[0]. Lane 1 sends b[1],b[0],g[5],g[4],g[3],g[2],g[1]. Lane 2 sends DE,VS,HS,b[5],b[4],b[3],b[2]. Lane 3 sends 0,b[7],b[6],g[7],g[6],r[7],r[6].
- R7: In the two 24-bit modes, the control slots are fixed: lane 2 sends DE, VS and HS in slots 0, 1 and 2, and lane 3 sends 0 in slot 0.
- R8: With `mirror`=1, wire slot k of every data lane carries the bit that slot 6-k carries with `mirror`=0.
- R9: With `map_sel`=3 (reserved), all four data lanes are low for the whole pixel while the clock lane keeps its pattern.
- R10: Changes on the pixel inputs, `map_sel` or `mirror` in cycles where `pix_load` is low do not alter the pixel being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ser | input | 1 | Serial clock, seven per pixel |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| red | input | 8 | Red channel |
| green | input | 8 | Green channel |
| blue | input | 8 | Blue channel |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| den | input | 1 | Data enable |
| map_sel | input | 2 | Ordering: 0 18-bit, 1 24-bit low-bits-on-lane-3, 2 24-bit high-bits-on-lane-3, 3 reserved |
| mirror | input | 1 | Reverse the slot order on data lanes |
| pix_load | output | 1 | High in the cycle whose closing edge captures the pixel |
| data_lane | output | 4 | Serial data lanes, bit n is lane n |
| clk_lane | output | 1 | Serial clock-lane pattern |

## Verification
A pixel driven while `pix_load` is high shows wire slot 0 one clock later, because one shift-register stage sits between the capture edge and the lane outputs. Slot k then follows k clocks after that. The bench drives on the falling edge where `pix_load` is high. It collects the seven following falling-edge samples of each lane into a word and compares it with a word built from a slot-to-source table. After reset release, the two-stage reset synchronizer holds the first capture back two clocks, and the bench waits those two clocks before its first pixel. The inputs are then disturbed in the middle of a pixel to confirm that only the boundary sample counts.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;
  localparam int unsigned SLOT_N = 7;
  localparam int unsigned LANE_N = 4;
  localparam int unsigned CHAN_W = 8;
  localparam int unsigned SLOT_W = $clog2(SLOT_N);

  typedef logic [SLOT_N-1:0] slot_word_t;
  typedef slot_word_t [LANE_N-1:0] lane_set_t;

  typedef enum logic [1:0] {
    MAP_NARROW = 2'd0,
    MAP_WIDE_LO = 2'd1,
    MAP_WIDE_HI = 2'd2,
    MAP_OFF = 2'd3
  } map_e;

  // Clock-lane pattern, bit k is wire slot k.
  localparam slot_word_t CLK_PATTERN = 7'b1100011;

  function automatic slot_word_t pack_slots(input logic s0, input logic s1,
                                            input logic s2, input logic s3,
                                            input logic s4, input logic s5,
                                            input logic s6);
    return {s6, s5, s4, s3, s2, s1, s0};
  endfunction

  function automatic slot_word_t flip_slots(input slot_word_t w);
    slot_word_t f;
    for (int k = 0; k < SLOT_N; k++) f[k] = w[SLOT_N-1-k];
    return f;
  endfunction
endpackage

// File: rtl/lvds_rst_sync.sv
module lvds_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/lvds_slot_timer.sv
module lvds_slot_timer
  import lvds_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot,
  output logic              last
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOT_N - 1);

  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_d;

  always_comb begin
    last   = (slot_q == LAST_SLOT);
    slot_d = last ? '0 : slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= LAST_SLOT;
    else        slot_q <= slot_d;
  end

  assign slot = slot_q;
endmodule

// File: rtl/lvds_slot_mapper.sv
module lvds_slot_mapper
  import lvds_ser_pkg::*;
(
  input  logic [CHAN_W-1:0] red,
  input  logic [CHAN_W-1:0] green,
  input  logic [CHAN_W-1:0] blue,
  input  logic              hsync,
  input  logic              vsync,
  input  logic              den,
  input  logic [1:0]        map_sel,
  input  logic              mirror,
  output lane_set_t         words
);
  localparam int unsigned MSB = CHAN_W - 1;

  lane_set_t natural;

  function automatic lane_set_t base_three(input logic [5:0] r6,
                                           input logic [5:0] g6,
                                           input logic [5:0] b6,
                                           input logic hs, input logic vs,
                                           input logic de);
    lane_set_t s;
    s    = '0;
    s[0] = pack_slots(g6[0], r6[5], r6[4], r6[3], r6[2], r6[1], r6[0]);
    s[1] = pack_slots(b6[1], b6[0], g6[5], g6[4], g6[3], g6[2], g6[1]);
    s[2] = pack_slots(de, vs, hs, b6[5], b6[4], b6[3], b6[2]);
    return s;
  endfunction

  always_comb begin
    natural = '0;
    case (map_e'(map_sel))
      MAP_NARROW: begin
        natural = base_three(red[MSB -: 6], green[MSB -: 6], blue[MSB -: 6],
                             hsync, vsync, den);
      end
      MAP_WIDE_LO: begin
        natural    = base_three(red[MSB -: 6], green[MSB -: 6], blue[MSB -: 6],
                                hsync, vsync, den);
        natural[3] = pack_slots(1'b0, blue[1], blue[0], green[1], green[0],
                                red[1], red[0]);
      end
      MAP_WIDE_HI: begin
        natural    = base_three(red[5:0], green[5:0], blue[5:0],
                                hsync, vsync, den);
        natural[3] = pack_slots(1'b0, blue[MSB], blue[MSB-1], green[MSB],
                                green[MSB-1], red[MSB], red[MSB-1]);
      end
      default: natural = '0;
    endcase
  end

  for (genvar l = 0; l < LANE_N; l++) begin : g_orient
    assign words[l] = mirror ? flip_slots(natural[l]) : natural[l];
  end
endmodule

// File: rtl/lvds_lane_shifter.sv
module lvds_lane_shifter
  import lvds_ser_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  slot_word_t load_word,
  output logic       ser_out
);
  slot_word_t shift_q;
  slot_word_t shift_d;

  always_comb begin
    if (load) shift_d = load_word;
    else      shift_d = {1'b0, shift_q[SLOT_N-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign ser_out = shift_q[0];
endmodule

// File: rtl/lvds_pixel_serializer.sv
module lvds_pixel_serializer
  import lvds_ser_pkg::*;
(
  input  logic              clk_ser,
  input  logic              rst_n,
  input  logic [CHAN_W-1:0] red,
  input  logic [CHAN_W-1:0] green,
  input  logic [CHAN_W-1:0] blue,
  input  logic              hsync,
  input  logic              vsync,
  input  logic              den,
  input  logic [1:0]        map_sel,
  input  logic              mirror,
  output logic              pix_load,
  output logic [LANE_N-1:0] data_lane,
  output logic              clk_lane
);
  logic              rst_n_sync;
  logic [SLOT_W-1:0] slot_now;
  logic              slot_last;
  lane_set_t         data_words;

  lvds_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk_ser),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  lvds_slot_timer u_timer (
    .clk   (clk_ser),
    .rst_n (rst_n_sync),
    .slot  (slot_now),
    .last  (slot_last)
  );

  lvds_slot_mapper u_map (
    .red     (red),
    .green   (green),
    .blue    (blue),
    .hsync   (hsync),
    .vsync   (vsync),
    .den     (den),
    .map_sel (map_sel),
    .mirror  (mirror),
    .words   (data_words)
  );

  for (genvar l = 0; l < LANE_N; l++) begin : g_data
    lvds_lane_shifter u_shift (
      .clk       (clk_ser),
      .rst_n     (rst_n_sync),
      .load      (slot_last),
      .load_word (data_words[l]),
      .ser_out   (data_lane[l])
    );
  end

  lvds_lane_shifter u_clk_shift (
    .clk       (clk_ser),
    .rst_n     (rst_n_sync),
    .load      (slot_last),
    .load_word (CLK_PATTERN),
    .ser_out   (clk_lane)
  );

  assign pix_load = slot_last;

  logic [SLOT_W-1:0] slot_unused;
  assign slot_unused = slot_now;
endmodule

// File: rtl/lvds_serializer_checker.sv
module lvds_serializer_checker
  import lvds_ser_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              pix_load,
  input logic [LANE_N-1:0] data_lane,
  input logic              clk_lane,
  input logic [1:0]        map_sel,
  input logic              mirror
);
  logic [SLOT_W-1:0] cnt;
  logic              seen;
  logic [1:0]        held_map;
  logic              held_mir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      seen     <= 1'b0;
      held_map <= 2'd0;
      held_mir <= 1'b0;
    end else if (pix_load) begin
      cnt      <= '0;
      seen     <= 1'b1;
      held_map <= map_sel;
      held_mir <= mirror;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2
  period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (pix_load == (cnt == SLOT_W'(SLOT_N - 1))));

  // R2
  single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_load |=> !pix_load || !seen);

  // R3
  clk_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (clk_lane == (cnt < 3'd2 || cnt > 3'd4)));

  // R9
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && held_map == 2'd3) |-> (data_lane == '0));

  // R4
  narrow_lane3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && held_map == 2'd0) |-> !data_lane[3]);

  // R7
  ctl3_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && cnt == (held_mir ? 3'd6 : 3'd0)) |-> !data_lane[3]);
endmodule

bind lvds_pixel_serializer lvds_serializer_checker u_chk (
  .clk       (clk_ser),
  .rst_n     (rst_n_sync),
  .pix_load  (pix_load),
  .data_lane (data_lane),
  .clk_lane  (clk_lane),
  .map_sel   (map_sel),
  .mirror    (mirror)
);

// File: tb/sim_lvds_pixel_serializer.sv
module sim_lvds_pixel_serializer;
  logic       clk_ser = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] red = '0, green = '0, blue = '0;
  logic       hsync = 1'b0, vsync = 1'b0, den = 1'b0;
  logic [1:0] map_sel = '0;
  logic       mirror = 1'b0;
  logic       pix_load;
  logic [3:0] data_lane;
  logic       clk_lane;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_ser = ~clk_ser;

  lvds_pixel_serializer u0 (
    .clk_ser(clk_ser), .rst_n(rst_n), .red(red), .green(green), .blue(blue),
    .hsync(hsync), .vsync(vsync), .den(den), .map_sel(map_sel),
    .mirror(mirror), .pix_load(pix_load), .data_lane(data_lane),
    .clk_lane(clk_lane)
  );

  // Source index: 0-7 red, 8-15 green, 16-23 blue, 24 HS, 25 VS, 26 DE, 27 zero
  function automatic int src_idx(int m, int l, int s);
    int t[7];
    t = '{27, 27, 27, 27, 27, 27, 27};
    if (m == 0 || m == 1) begin
      case (l)
        0: t = '{10, 7, 6, 5, 4, 3, 2};
        1: t = '{19, 18, 15, 14, 13, 12, 11};
        2: t = '{26, 25, 24, 23, 22, 21, 20};
        default: if (m == 1) t = '{27, 17, 16, 9, 8, 1, 0};
      endcase
    end else if (m == 2) begin
      case (l)
        0: t = '{8, 5, 4, 3, 2, 1, 0};
        1: t = '{17, 16, 13, 12, 11, 10, 9};
        2: t = '{26, 25, 24, 21, 20, 19, 18};
        default: t = '{27, 23, 22, 15, 14, 7, 6};
      endcase
    end
    return t[s];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [27:0] px, int m, bit mir);
    red = px[7:0]; green = px[15:8]; blue = px[23:16];
    hsync = px[24]; vsync = px[25]; den = px[26];
    map_sel = 2'(m); mirror = mir;
  endtask

  // Called on a falling edge with pix_load high; returns on the next such edge.
  task automatic send(logic [27:0] px_in, int m, bit mir, bit disturb);
    logic [27:0] px;
    logic [6:0] got [4];
    logic [6:0] gclk, gload;
    string tag;
    px = px_in;
    px[27] = 1'b0;
    apply(px, m, mir);
    for (int s = 0; s < 7; s++) begin
      @(negedge clk_ser);
      for (int l = 0; l < 4; l++) got[l][s] = data_lane[l];
      gclk[s] = clk_lane;
      gload[s] = pix_load;
      if (disturb && s == 2) apply(~px, (m + 1) % 4, ~mir);
    end
    tag = (m == 0) ? "R4" : (m == 1) ? "R5" : (m == 2) ? "R6" : "R9";
    if (mir) tag = {tag, "/R8"};
    if (disturb) tag = {tag, "/R10"};
    for (int l = 0; l < 4; l++) begin
      logic [6:0] e;
      for (int s = 0; s < 7; s++) e[s] = px[src_idx(m, l, mir ? 6 - s : s)];
      chk(got[l] == e, $sformatf("%s lane%0d", tag, l), got[l], e);
    end
    chk(gclk == 7'b1100011, "R3 clock lane", gclk, 7'b1100011);
    chk(gload == 7'b1000000, "R2 load strobe", gload, 7'b1000000);
    if (!mir && (m == 1 || m == 2)) begin
      logic [3:0] ctl, ectl;
      ctl  = {got[3][0], got[2][2], got[2][1], got[2][0]};
      ectl = {1'b0, px[24], px[25], px[26]};
      chk(ctl == ectl, "R7 control slots", ctl, ectl);
    end
    if (disturb) apply(px, m, mir);
  endtask

  initial begin
    repeat (200000) @(posedge clk_ser);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk_ser);
    // R1: reset state
    chk(data_lane == 4'b0 && clk_lane == 1'b0 && pix_load == 1'b1, "R1 reset",
        {data_lane, clk_lane, pix_load}, 6'b000001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk_ser);
    chk(data_lane == 4'b0 && clk_lane == 1'b0 && pix_load == 1'b1,
        "R1 after release", {data_lane, clk_lane, pix_load}, 6'b000001);
    for (int m = 0; m < 4; m++) begin
      for (int mir = 0; mir < 2; mir++) begin
        for (int b = 0; b < 27; b++) send(28'(1) << b, m, bit'(mir), 1'b0);
        send(28'hfffffff, m, bit'(mir), 1'b0);
        for (int r = 0; r < 4; r++) send(28'($urandom), m, bit'(mir), 1'b0);
      end
    end
    // R10: inputs disturbed between boundaries
    for (int m = 0; m < 4; m++) begin
      send(28'h5a3c96e, m, 1'b0, 1'b1);
      send(28'h2c5f013, m, 1'b1, 1'b1);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule